// File: doc/BRIEF.md
# Slave-Mode Trigger Timer

This block is an up/down counter whose advance, start, reload and direction come from a slave-mode controller. A 3-bit mode input picks how the counter moves. It can be clocked every cycle, decoded from two quadrature inputs, reloaded by a trigger, gated by a trigger level, started by a trigger, or stepped by trigger edges. A 3-bit selector register names the trigger source. The sources are an internal trigger line, a both-edge detector on the first timer input, either filtered timer input, and an external trigger line.

All inputs arrive already filtered and synchronous to `clk`. The counter wraps between zero and a programmable top value `arr`. The outputs are the count, a direction flag, a one-cycle update pulse after each trigger-driven reload, a flag for the illegal gated/edge-detector pairing, and the latched start state of trigger mode.

Top module: `slave_trig_timer`

## Requirements
- R1: After reset the count is 0, and `dir`, `upd`, `err` and `run` are 0. The trigger selector holds 000.
- R2: The selector codes are: 000 picks `itr0`; 100 picks the edge detector on `ti1`; 101 picks `ti1`; 110 picks `ti2`; 111 picks `etr`. The codes 001, 010 and 011 give a trigger that is always low.
- R3: `tsel_wr` loads `tsel_data` into the selector only while `slave_mode` is 000. In every other mode the write is ignored.
- R4: The edge-detector source is high for exactly one cycle after each change of `ti1`, whether the change is rising or falling.
- R5: In mode 000 the count steps once per cycle while `cnt_en` is 1. `dir_down`=1 counts down and `dir_down`=0 counts up. Counting up from `arr` (or above it) gives 0, and counting down from 0 gives `arr`. Outside the encoder modes, `dir` equals `dir_down` from the cycle before.
- R6: In mode 001 each change of `ti1` alone steps the count. The step is up when `ti1` XOR `ti2` is 1 after the change, and down otherwise. A change of `ti2` alone does not step the count.
- R7: Mode 010 steps only on a change of `ti2` alone, up when `ti1`==`ti2`. Mode 011 steps on a change of either input alone, with the matching rule for that input. When both inputs change in the same cycle, no step is taken. After each encoder step, `dir` is 1 for down and 0 for up.
- R8: In mode 100 a rising trigger loads 0 (`dir_down`=0) or `arr` (`dir_down`=1), and `upd` is 1 for the following cycle only. Without a rising trigger, the count behaves as in R5.
- R9: In mode 101 the count steps as in R5 only in cycles where the trigger is high. It holds, and is not cleared, while the trigger is low.
- R10: In mode 110 a rising trigger sets `run`, and from the next cycle the count steps every cycle while `run` is 1. `run` is cleared whenever the mode is not 110.
- R11: In mode 111 the count steps by one on each rising edge of the selected trigger, independent of `cnt_en`.
- R12: While the mode is 101 and the selector holds 100, `err` is 1 and the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counter enable for the internal, reset and gated modes |
| dir_down | input | 1 | Count direction outside the encoder modes (1 = down) |
| arr | input | CNT_W | Wrap / top value |
| slave_mode | input | 3 | Slave-mode code |
| tsel_wr | input | 1 | Selector write strobe |
| tsel_data | input | 3 | Selector write value |
| itr0 | input | 1 | Internal trigger line |
| ti1 | input | 1 | Filtered timer input 1 |
| ti2 | input | 1 | Filtered timer input 2 |
| etr | input | 1 | External trigger line |
| count | output | CNT_W | Counter value |
| dir | output | 1 | Direction flag (1 = down) |
| upd | output | 1 | Update pulse after a trigger reload |
| err | output | 1 | Illegal gated/edge-detector pairing |
| run | output | 1 | Trigger-mode start latch |

## Verification
The bench builds the block with its default 16-bit counter and drives `arr` with small values between 3 and 12. With those values, wraps in both directions and reloads to the top value occur within a few cycles of any mode. Random mode changes, selector writes and input toggles reach every mode with every trigger source, including the illegal gated pairing. Directed sequences fix the selector-lock, edge-detector, reload and quadrature cases to known counts.

// File: rtl/stt_pkg.sv
package stt_pkg;
   typedef enum logic [2:0] {
      SM_FREE   = 3'd0,
      SM_QUAD_A = 3'd1,
      SM_QUAD_B = 3'd2,
      SM_QUAD_AB= 3'd3,
      SM_RELOAD = 3'd4,
      SM_GATE   = 3'd5,
      SM_START  = 3'd6,
      SM_EXTCLK = 3'd7
   } smode_t;

   localparam logic [2:0] SRC_ITR  = 3'b000;
   localparam logic [2:0] SRC_EDGE = 3'b100;
   localparam logic [2:0] SRC_IN1  = 3'b101;
   localparam logic [2:0] SRC_IN2  = 3'b110;
   localparam logic [2:0] SRC_EXT  = 3'b111;
endpackage

// File: rtl/stt_trig_sel.sv
module stt_trig_sel
   import stt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_free,
   input  logic       wr,
   input  logic [2:0] wdata,
   input  logic       itr0,
   input  logic       ti1,
   input  logic       ti2,
   input  logic       etr,
   input  logic       ti1_chg,
   output logic [2:0] sel,
   output logic       trg,
   output logic       trg_rise
);
   logic trg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                sel <= SRC_ITR;
      else if (wr && mode_free)  sel <= wdata;
   end

   always_comb begin
      case (sel)
         SRC_ITR:  trg = itr0;
         SRC_EDGE: trg = ti1_chg;
         SRC_IN1:  trg = ti1;
         SRC_IN2:  trg = ti2;
         SRC_EXT:  trg = etr;
         default:  trg = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trg_q <= 1'b0;
      else        trg_q <= trg;
   end

   assign trg_rise = trg & ~trg_q;

   // R3: selector moves only after a cycle in the free-running mode
   assert_sel_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel != $past(sel)) |-> $past(mode_free));
endmodule

// File: rtl/stt_quad_dec.sv
module stt_quad_dec
   import stt_pkg::*;
(
   input  smode_t     mode,
   input  logic       ti1,
   input  logic       ti2,
   input  logic       chg1,
   input  logic       chg2,
   output logic       q_step,
   output logic       q_up
);
   logic up_on1, up_on2;

   assign up_on1 = ti1 ^ ti2;
   assign up_on2 = ~(ti1 ^ ti2);

   always_comb begin
      q_step = 1'b0;
      q_up   = 1'b0;
      case (mode)
         SM_QUAD_A:  begin q_step = chg1 & ~chg2; q_up = up_on1; end
         SM_QUAD_B:  begin q_step = chg2 & ~chg1; q_up = up_on2; end
         SM_QUAD_AB: begin q_step = chg1 ^ chg2;  q_up = chg1 ? up_on1 : up_on2; end
         default:    ;
      endcase
   end
endmodule

// File: rtl/stt_counter.sv
module stt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             up,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] arr,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] nxt;

   always_comb begin
      if (up) nxt = (cnt >= arr) ? ZERO : cnt + ONE;
      else    nxt = (cnt == ZERO) ? arr : cnt - ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= ZERO;
      else if (load) cnt <= load_val;
      else if (step) cnt <= nxt;
   end

   // R5: a count inside the range stays inside it while the top is steady
   assert_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt) <= $past(arr) && $stable(arr)) |-> (cnt <= arr));
endmodule

// File: rtl/slave_trig_timer.sv
module slave_trig_timer
   import stt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             dir_down,
   input  logic [CNT_W-1:0] arr,
   input  logic [2:0]       slave_mode,
   input  logic             tsel_wr,
   input  logic [2:0]       tsel_data,
   input  logic             itr0,
   input  logic             ti1,
   input  logic             ti2,
   input  logic             etr,
   output logic [CNT_W-1:0] count,
   output logic             dir,
   output logic             upd,
   output logic             err,
   output logic             run
);
   localparam int NPIN = 2;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("CNT_W must lie in 2..32");
      end
   endgenerate

   smode_t           mode;
   logic [NPIN-1:0]  pin, pin_q, chg;
   logic [2:0]       sel;
   logic             trg, trg_rise, q_step, q_up;
   logic             step, up, load, is_quad;
   logic [CNT_W-1:0] load_val;

   assign mode = smode_t'(slave_mode);
   assign pin  = {ti2, ti1};

   for (genvar i = 0; i < NPIN; i++) begin : g_edge
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pin_q[i] <= 1'b0;
         else        pin_q[i] <= pin[i];
      end
      assign chg[i] = pin[i] ^ pin_q[i];
   end

   stt_trig_sel u_sel (
      .clk(clk), .rst_n(rst_n), .mode_free(mode == SM_FREE),
      .wr(tsel_wr), .wdata(tsel_data),
      .itr0(itr0), .ti1(ti1), .ti2(ti2), .etr(etr), .ti1_chg(chg[0]),
      .sel(sel), .trg(trg), .trg_rise(trg_rise));

   stt_quad_dec u_quad (
      .mode(mode), .ti1(ti1), .ti2(ti2), .chg1(chg[0]), .chg2(chg[1]),
      .q_step(q_step), .q_up(q_up));

   assign err     = (mode == SM_GATE) && (sel == SRC_EDGE);
   assign is_quad = (mode == SM_QUAD_A) || (mode == SM_QUAD_B) || (mode == SM_QUAD_AB);
   assign load_val = dir_down ? arr : '0;

   always_comb begin
      step = 1'b0;
      up   = ~dir_down;
      load = 1'b0;
      case (mode)
         SM_FREE:   step = cnt_en;
         SM_QUAD_A, SM_QUAD_B, SM_QUAD_AB: begin step = q_step; up = q_up; end
         SM_RELOAD: if (trg_rise) load = 1'b1; else step = cnt_en;
         SM_GATE:   step = cnt_en & trg & ~err;
         SM_START:  step = run;
         SM_EXTCLK: step = trg_rise;
         default:   ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         upd <= 1'b0;
         dir <= 1'b0;
      end else begin
         run <= (mode == SM_START) && (run || trg_rise);
         upd <= (mode == SM_RELOAD) && trg_rise;
         if (!is_quad)    dir <= dir_down;
         else if (q_step) dir <= ~q_up;
      end
   end

   stt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step), .up(up), .load(load),
      .load_val(load_val), .arr(arr), .cnt(count));

   // R8: the update pulse never lasts two cycles
   assert_upd_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> !upd);
   // R12: illegal pairing freezes the count
   assert_err_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> (count == $past(count)));
   // R10: start latch drops outside trigger-start mode
   assert_run_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != SM_START) |=> !run);
   // R8: a reload pulse follows only a cycle spent in reload mode
   assert_upd_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      upd |-> ($past(slave_mode) == 3'd4));
endmodule

// File: tb/tb_slave_trig_timer.sv
`timescale 1ns/1ps
module tb_slave_trig_timer;
   localparam int W = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cnt_en = 0, dir_down = 0, tsel_wr = 0, itr0 = 0, ti1 = 0, ti2 = 0, etr = 0;
   logic [W-1:0] arr = 16'd9;
   logic [2:0] slave_mode = 0, tsel_data = 0;
   logic [W-1:0] count;
   logic dir, upd, err, run;

   int n_chk = 0, n_fail = 0;

   logic [W-1:0] m_cnt;
   logic m_dir, m_upd, m_run, m_p1, m_p2, m_trgq;
   logic [2:0] m_tsel;

   always #2 clk = ~clk;

   slave_trig_timer #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .dir_down(dir_down), .arr(arr),
      .slave_mode(slave_mode), .tsel_wr(tsel_wr), .tsel_data(tsel_data),
      .itr0(itr0), .ti1(ti1), .ti2(ti2), .etr(etr),
      .count(count), .dir(dir), .upd(upd), .err(err), .run(run));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic string mtag(logic [2:0] m);
      case (m)
         3'd0: return "R5";
         3'd1: return "R6";
         3'd2, 3'd3: return "R7";
         3'd4: return "R8";
         3'd5: return "R9";
         3'd6: return "R10";
         default: return "R11 R2";
      endcase
   endfunction

   function automatic logic [W-1:0] wrap_step(logic [W-1:0] c, logic u, logic [W-1:0] top);
      if (u) return (c >= top) ? '0 : c + 1'b1;
      return (c == 0) ? top : c - 1'b1;
   endfunction

   task automatic model_next();
      logic c1, c2, trg, rise, qs, qu, st, u, ld, bad;
      c1 = ti1 ^ m_p1;
      c2 = ti2 ^ m_p2;
      case (m_tsel)
         3'd0: trg = itr0;
         3'd4: trg = c1;
         3'd5: trg = ti1;
         3'd6: trg = ti2;
         3'd7: trg = etr;
         default: trg = 1'b0;
      endcase
      rise = trg & ~m_trgq;
      qs = 0; qu = 0;
      case (slave_mode)
         3'd1: begin qs = c1 & ~c2; qu = ti1 ^ ti2; end
         3'd2: begin qs = c2 & ~c1; qu = ~(ti1 ^ ti2); end
         3'd3: begin qs = c1 ^ c2; qu = c1 ? (ti1 ^ ti2) : ~(ti1 ^ ti2); end
         default: ;
      endcase
      bad = (slave_mode == 3'd5) && (m_tsel == 3'd4);
      st = 0; u = ~dir_down; ld = 0;
      case (slave_mode)
         3'd0: st = cnt_en;
         3'd1, 3'd2, 3'd3: begin st = qs; u = qu; end
         3'd4: if (rise) ld = 1; else st = cnt_en;
         3'd5: st = cnt_en & trg & ~bad;
         3'd6: st = m_run;
         default: st = rise;
      endcase
      if (ld) m_cnt = dir_down ? arr : '0;
      else if (st) m_cnt = wrap_step(m_cnt, u, arr);
      m_upd = (slave_mode == 3'd4) && rise;
      m_run = (slave_mode == 3'd6) && (m_run || rise);
      if (slave_mode inside {3'd1, 3'd2, 3'd3}) begin
         if (qs) m_dir = ~qu;
      end else m_dir = dir_down;
      if (tsel_wr && slave_mode == 3'd0) m_tsel = tsel_data;
      m_p1 = ti1; m_p2 = ti2; m_trgq = trg;
   endtask

   // inputs are driven at a falling edge before this is called
   task automatic cyc();
      #1;
      chk("R12 err", err, (slave_mode == 3'd5) && (m_tsel == 3'd4));
      model_next();
      @(posedge clk);
      @(negedge clk);
      chk({mtag(slave_mode), " count"}, count, m_cnt);
      chk({mtag(slave_mode), " dir"}, dir, m_dir);
      chk("R8 upd", upd, m_upd);
      chk("R10 run", run, m_run);
   endtask

   task automatic set_sel(logic [2:0] code);
      slave_mode = 3'd0; cnt_en = 0; tsel_wr = 1; tsel_data = code;
      cyc();
      tsel_wr = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [W-1:0] c0;
      m_cnt = 0; m_dir = 0; m_upd = 0; m_run = 0; m_p1 = 0; m_p2 = 0; m_trgq = 0; m_tsel = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 count", count, 0);
      chk("R1 dir", dir, 0);
      chk("R1 upd", upd, 0);
      chk("R1 err", err, 0);
      chk("R1 run", run, 0);

      // R3: selector write ignored outside mode 000
      set_sel(3'd7);
      slave_mode = 3'd7; tsel_wr = 1; tsel_data = 3'd5; cyc();
      tsel_wr = 0; ti1 = 1; cyc();
      ti1 = 0; cyc();
      chk("R3 locked selector", count, 0);
      etr = 1; cyc();
      chk("R11 ext edge", count, 1);
      etr = 0; cyc();

      // R4: edge detector fires on both edges
      set_sel(3'd4);
      slave_mode = 3'd7; ti1 = 1; cyc();
      cyc();
      ti1 = 0; cyc();
      cyc();
      chk("R4 both edges", count, 3);

      // R12: gated with edge detector holds the count
      slave_mode = 3'd5; cnt_en = 1;
      for (int i = 0; i < 4; i++) begin ti1 = ~ti1; cyc(); end
      chk("R12 hold", count, 3);
      chk("R12 flag", err, 1);

      // R8: reload on rising trigger
      set_sel(3'd7);
      slave_mode = 3'd4; cnt_en = 1; dir_down = 0; cyc(); cyc();
      etr = 1; cyc();
      chk("R8 load zero", count, 0);
      chk("R8 pulse", upd, 1);
      cyc();
      chk("R8 pulse single", upd, 0);
      dir_down = 1; etr = 0; cyc();
      etr = 1; cyc();
      chk("R8 load top", count, 9);
      etr = 0; dir_down = 0; cnt_en = 0;

      // R6 R7: quadrature forward then reverse
      slave_mode = 3'd0; ti1 = 0; ti2 = 0; cyc();
      c0 = count;
      slave_mode = 3'd3;
      ti1 = 1; cyc(); ti2 = 1; cyc(); ti1 = 0; cyc(); ti2 = 0; cyc();
      chk("R7 forward", count, (c0 + 4) % 10);
      chk("R7 dir up", dir, 0);
      ti2 = 1; cyc();
      chk("R7 reverse", count, (c0 + 3) % 10);
      chk("R7 dir down", dir, 1);
      slave_mode = 3'd1; ti2 = 0; cyc();
      chk("R6 other input ignored", count, (c0 + 3) % 10);

      // random phase
      for (int n = 0; n < 3000; n++) begin
         if ($urandom_range(0, 19) == 0) slave_mode = 3'($urandom_range(0, 7));
         if ($urandom_range(0, 199) == 0) arr = 16'($urandom_range(3, 12));
         tsel_wr   = ($urandom_range(0, 9) == 0);
         tsel_data = 3'($urandom_range(0, 7));
         cnt_en    = ($urandom_range(0, 3) != 0);
         if ($urandom_range(0, 9) == 0) dir_down = ~dir_down;
         if ($urandom_range(0, 3) == 0) ti1 = ~ti1;
         if ($urandom_range(0, 3) == 0) ti2 = ~ti2;
         if ($urandom_range(0, 4) == 0) etr = ~etr;
         if ($urandom_range(0, 4) == 0) itr0 = ~itr0;
         cyc();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial void'($urandom(32'd1234));
endmodule